// File: doc/BRIEF.md
# Edge-Triggered Conversion Sequencer

This block ties analog-to-digital conversions to a pulse on an external hardware trigger line. The host arms it. The block then waits for the selected trigger to rise and lets a programmable hold-off pass. It then asks the converter for one sample. Next it waits for the same trigger to fall, lets the hold-off pass again, and takes a second sample. Both samples are kept in their own result registers. A single completion pulse marks the end of the pair, and the block returns to idle.

Two conditions stop the sequence in a fault state:
- The rising edge does not come within a programmable number of millisecond ticks.
- The converter does not answer a request within a fixed cycle budget.

Only an explicit host clear leaves the fault state. Time is measured with two external strobes: a 25 us tick for the hold-off and a 1 ms tick for the timeout. The trigger sources pass through a synchronizer inside the block. The current state is always visible on a port.

Top module: `edge_conv_seq`

## Requirements
- R1: After reset the state port reads 0 (idle), the request line and the completion pulse are low, and both result registers read zero.
- R2: An arm pulse in idle moves the state to 1 (wait for rise). An arm pulse in any other state has no effect.
- R3: The four trigger inputs each pass through a two-flop synchronizer. Trigger input number `trig_sel` (0 to 3) is the only one watched. A rise on it changes the state from 1 to 2 (rising hold-off) on the third clock edge after the input changes. Activity on the other inputs is ignored.
- R4: A hold-off state lasts exactly `holdoff_code`+1 pulses of the 25 us tick. It then moves to the following measure state, where `adc_req` is high.
- R5: In state 3 (first measure), `adc_done` loads `adc_data` into `rise_result` and moves the state to 4 (wait for fall).
- R6: A fall on the watched trigger moves state 4 to state 5 (falling hold-off). State 5 takes the same tick count as in R4 before moving to state 6 (second measure).
- R7: In state 6, `adc_done` loads `adc_data` into `fall_result`. On the next cycle the block raises `seq_done` for exactly one cycle and returns to state 0.
- R8: In state 1, a nonzero `timeout_code` sends the block to state 7 (fault) on the `timeout_code`-th 1 ms tick if no rise has come. A rise in the same cycle wins. A code of 0 never times out.
- R9: In a measure state (3 or 6), if `adc_done` stays low for WDOG_CYCLES clock cycles, the block moves to state 7.
- R10: State 7 persists until a `clear` pulse, which returns the block to state 0. Outside state 7, `clear` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Host start pulse |
| clear | input | 1 | Host fault clear pulse |
| trig_in | input | 4 | Raw hardware trigger sources |
| trig_sel | input | 2 | Index of the watched trigger source |
| holdoff_code | input | 4 | Hold-off length minus one, in 25 us ticks |
| timeout_code | input | 4 | Rise timeout in 1 ms ticks, 0 disables |
| tick_25us | input | 1 | One-cycle strobe every 25 us |
| tick_1ms | input | 1 | One-cycle strobe every 1 ms |
| adc_req | output | 1 | Conversion request, high in the measure states |
| adc_done | input | 1 | Converter result valid strobe |
| adc_data | input | 12 | Converter result |
| rise_result | output | 12 | Sample taken after the rising edge |
| fall_result | output | 12 | Sample taken after the falling edge |
| seq_done | output | 1 | One-cycle pulse when both samples are stored |
| state_o | output | 3 | Current state code (0 to 7) |

## Verification
On every cycle the assertions check several rules:
- The hold-off states wait for a tick.
- Idle can only move to the wait-for-rise state.
- The fault state stays put without a clear.
- The result registers change only on a handshake in their own measure state.
- The completion pulse is one cycle long and follows a second-sample handshake.

Some behaviour only the bench scenarios can show. One is the exact count of hold-off ticks for each of the sixteen codes. Others are the exact timeout tick for each nonzero code and the synchronizer latency. The bench also covers the watchdog cycle budget and the independence from non-selected sources.

// File: rtl/edge_conv_seq_pkg.sv
package edge_conv_seq_pkg;
   // Encoding is visible to the host through state_o; order follows the sequence.
   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_WAIT_RISE = 3'd1,
      ST_HOLD_RISE = 3'd2,
      ST_MEAS_RISE = 3'd3,
      ST_WAIT_FALL = 3'd4,
      ST_HOLD_FALL = 3'd5,
      ST_MEAS_FALL = 3'd6,
      ST_FAULT     = 3'd7
   } seq_state_t;
endpackage

// File: rtl/seq_tick_counter.sv
module seq_tick_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);
   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("seq_tick_counter: CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
   parameter int NSRC   = 4,
   parameter int STAGES = 2,
   localparam int SEL_W = $clog2(NSRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  trig_in,
   input  logic [SEL_W-1:0] sel,
   output logic             rise,
   output logic             fall
);
   logic [NSRC-1:0] synced;
   logic            watched_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("trig_edge_det: at least two synchronizer stages required");
      end
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], trig_in[s]};
         end
         assign synced[s] = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) watched_q <= 1'b0;
      else        watched_q <= synced[sel];
   end

   assign rise =  synced[sel] & ~watched_q;
   assign fall = ~synced[sel] &  watched_q;
endmodule

// File: rtl/edge_conv_seq.sv
module edge_conv_seq
   import edge_conv_seq_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int NSRC        = 4,
   parameter int SYNC_STAGES = 2,
   parameter int CODE_W      = 4,
   parameter int WDOG_CYCLES = 64,
   localparam int SEL_W      = $clog2(NSRC),
   localparam int WDOG_W     = $clog2(WDOG_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              clear,
   input  logic [NSRC-1:0]   trig_in,
   input  logic [SEL_W-1:0]  trig_sel,
   input  logic [CODE_W-1:0] holdoff_code,
   input  logic [CODE_W-1:0] timeout_code,
   input  logic              tick_25us,
   input  logic              tick_1ms,
   output logic              adc_req,
   input  logic              adc_done,
   input  logic [DATA_W-1:0] adc_data,
   output logic [DATA_W-1:0] rise_result,
   output logic [DATA_W-1:0] fall_result,
   output logic              seq_done,
   output logic [2:0]        state_o
);
   generate
      if (WDOG_CYCLES < 2) begin : g_bad_wdog
         $error("edge_conv_seq: WDOG_CYCLES must be at least 2");
      end
      if (NSRC < 2) begin : g_bad_nsrc
         $error("edge_conv_seq: NSRC must be at least 2");
      end
   endgenerate

   seq_state_t state, nxt;
   logic trig_rise, trig_fall;
   logic [CODE_W-1:0] hold_cnt, tmo_cnt;
   logic [WDOG_W-1:0] wd_cnt;
   logic in_hold, in_meas, hold_hit, tmo_hit, wd_hit;

   trig_edge_det #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sel(trig_sel),
      .rise(trig_rise), .fall(trig_fall)
   );

   assign in_hold = (state == ST_HOLD_RISE) || (state == ST_HOLD_FALL);
   assign in_meas = (state == ST_MEAS_RISE) || (state == ST_MEAS_FALL);

   seq_tick_counter #(.CNT_W(CODE_W)) u_hold_cnt (
      .clk(clk), .rst_n(rst_n), .clr(!in_hold), .tick(tick_25us), .cnt(hold_cnt)
   );
   seq_tick_counter #(.CNT_W(CODE_W)) u_tmo_cnt (
      .clk(clk), .rst_n(rst_n), .clr(state != ST_WAIT_RISE), .tick(tick_1ms), .cnt(tmo_cnt)
   );
   seq_tick_counter #(.CNT_W(WDOG_W)) u_wd_cnt (
      .clk(clk), .rst_n(rst_n), .clr(!in_meas), .tick(1'b1), .cnt(wd_cnt)
   );

   assign hold_hit = tick_25us && (hold_cnt == holdoff_code);
   assign tmo_hit  = tick_1ms && (timeout_code != '0) &&
                     (tmo_cnt == timeout_code - CODE_W'(1));
   assign wd_hit   = (wd_cnt == WDOG_W'(WDOG_CYCLES - 1));

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:      if (arm) nxt = ST_WAIT_RISE;
         ST_WAIT_RISE: if (trig_rise) nxt = ST_HOLD_RISE;
                       else if (tmo_hit) nxt = ST_FAULT;
         ST_HOLD_RISE: if (hold_hit) nxt = ST_MEAS_RISE;
         ST_MEAS_RISE: if (adc_done) nxt = ST_WAIT_FALL;
                       else if (wd_hit) nxt = ST_FAULT;
         ST_WAIT_FALL: if (trig_fall) nxt = ST_HOLD_FALL;
         ST_HOLD_FALL: if (hold_hit) nxt = ST_MEAS_FALL;
         ST_MEAS_FALL: if (adc_done) nxt = ST_IDLE;
                       else if (wd_hit) nxt = ST_FAULT;
         ST_FAULT:     if (clear) nxt = ST_IDLE;
         default:      nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         rise_result <= '0;
         fall_result <= '0;
         seq_done    <= 1'b0;
      end else begin
         state    <= nxt;
         seq_done <= (state == ST_MEAS_FALL) && adc_done;
         if ((state == ST_MEAS_RISE) && adc_done) rise_result <= adc_data;
         if ((state == ST_MEAS_FALL) && adc_done) fall_result <= adc_data;
      end
   end

   assign adc_req = in_meas;
   assign state_o = state;
endmodule

// File: rtl/edge_conv_seq_chk.sv
module edge_conv_seq_chk #(
   parameter int DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm,
   input logic              clear,
   input logic              tick_25us,
   input logic              adc_done,
   input logic [DATA_W-1:0] rise_result,
   input logic [DATA_W-1:0] fall_result,
   input logic              seq_done,
   input logic [2:0]        state_o
);
   // R2: idle can only stay or advance to wait-for-rise
   assert_idle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd0) |=> (state_o == 3'd0 || state_o == 3'd1));

   // R4: a hold-off state never ends without a 25 us tick
   assert_hold_rise_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd2 && !tick_25us) |=> (state_o == 3'd2));
   assert_hold_fall_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd5 && !tick_25us) |=> (state_o == 3'd5));

   // R5: first result only changes on a handshake in the first measure state
   assert_rise_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(state_o == 3'd3 && adc_done) |=> $stable(rise_result));

   // R7: second result and completion pulse follow a handshake in state 6
   assert_fall_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(state_o == 3'd6 && adc_done) |=> $stable(fall_result));
   assert_done_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> ($past(state_o) == 3'd6 && $past(adc_done)));
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   // R10: fault persists without clear
   assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd7 && !clear) |=> (state_o == 3'd7));
endmodule

bind edge_conv_seq edge_conv_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .arm(arm), .clear(clear), .tick_25us(tick_25us),
   .adc_done(adc_done), .rise_result(rise_result), .fall_result(fall_result),
   .seq_done(seq_done), .state_o(state_o)
);

// File: tb/edge_conv_seq_test.sv
module edge_conv_seq_test;
   localparam int DW   = 12;
   localparam int WDOG = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 0, clear = 0, tick_25us = 0, tick_1ms = 0, adc_done = 0;
   logic [3:0] trig_in = '0;
   logic [1:0] trig_sel = '0;
   logic [3:0] holdoff_code = '0, timeout_code = '0;
   logic [DW-1:0] adc_data = '0;
   logic adc_req, seq_done;
   logic [DW-1:0] rise_result, fall_result;
   logic [2:0] state_o;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   edge_conv_seq #(.DATA_W(DW), .WDOG_CYCLES(WDOG)) uut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .clear(clear), .trig_in(trig_in),
      .trig_sel(trig_sel), .holdoff_code(holdoff_code), .timeout_code(timeout_code),
      .tick_25us(tick_25us), .tick_1ms(tick_1ms), .adc_req(adc_req),
      .adc_done(adc_done), .adc_data(adc_data), .rise_result(rise_result),
      .fall_result(fall_result), .seq_done(seq_done), .state_o(state_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_arm();
      arm = 1; cyc(1); arm = 0;
   endtask

   task automatic pulse_clear();
      clear = 1; cyc(1); clear = 0;
   endtask

   task automatic t25();
      tick_25us = 1; cyc(1); tick_25us = 0;
   endtask

   task automatic t1ms();
      tick_1ms = 1; cyc(1); tick_1ms = 0;
   endtask

   task automatic do_reset();
      rst_n = 0; trig_in = '0; cyc(2); rst_n = 1; cyc(1);
   endtask

   // Hold-off of code+1 ticks; expected next state nst with request high.
   task automatic hold_phase(input int code, input int hst, input int nst, input string tag);
      for (int i = 0; i < code; i++) begin
         t25();
         chk(state_o == 3'(hst), tag, state_o, hst);
      end
      t25();
      chk(state_o == 3'(nst) && adc_req, tag, state_o, nst);
   endtask

   task automatic full_run(input int sel, input int hcode, input int rv, input int fv);
      int other;
      trig_sel = 2'(sel); holdoff_code = 4'(hcode); timeout_code = 4'd15;
      pulse_arm();
      chk(state_o == 3'd1, "R2 arm from idle", state_o, 1);
      other = (sel + 1) % 4;
      trig_in[other] = 1'b1; cyc(5);
      chk(state_o == 3'd1, "R3 other source ignored", state_o, 1);
      trig_in[other] = 1'b0; cyc(4);
      trig_in[sel] = 1'b1; cyc(2);
      chk(state_o == 3'd1, "R3 sync latency", state_o, 1);
      cyc(1);
      chk(state_o == 3'd2, "R3 rise detected", state_o, 2);
      hold_phase(hcode, 2, 3, "R4 rising hold-off");
      adc_data = DW'(rv); adc_done = 1; cyc(1); adc_done = 0;
      chk(state_o == 3'd4, "R5 state after first sample", state_o, 4);
      chk(rise_result == DW'(rv), "R5 rise_result", rise_result, rv);
      pulse_arm();
      chk(state_o == 3'd4, "R2 arm ignored when busy", state_o, 4);
      trig_in[sel] = 1'b0; cyc(3);
      chk(state_o == 3'd5, "R6 fall detected", state_o, 5);
      hold_phase(hcode, 5, 6, "R6 falling hold-off");
      adc_data = DW'(fv); adc_done = 1; cyc(1); adc_done = 0;
      chk(seq_done == 1'b1, "R7 done pulse", seq_done, 1);
      chk(state_o == 3'd0, "R7 back to idle", state_o, 0);
      chk(fall_result == DW'(fv), "R7 fall_result", fall_result, fv);
      cyc(1);
      chk(seq_done == 1'b0, "R7 done single cycle", seq_done, 0);
   endtask

   initial begin
      do_reset();
      chk(state_o == 3'd0 && !adc_req && !seq_done, "R1 reset state", state_o, 0);
      chk(rise_result == '0 && fall_result == '0, "R1 reset results", rise_result, 0);
      pulse_clear();
      chk(state_o == 3'd0, "R10 clear ignored in idle", state_o, 0);

      // Sweep every hold-off code, rotating the watched source.
      for (int h = 0; h < 16; h++)
         full_run(h % 4, h, 100 + 7 * h, 3000 - 11 * h);

      // Timeout sweep over all nonzero codes.
      trig_sel = 2'd0;
      for (int tc = 1; tc < 16; tc++) begin
         timeout_code = 4'(tc);
         pulse_arm();
         pulse_clear();
         chk(state_o == 3'd1, "R10 clear ignored while waiting", state_o, 1);
         for (int i = 0; i < tc - 1; i++) t1ms();
         chk(state_o == 3'd1, "R8 no fault before limit", state_o, 1);
         t1ms();
         chk(state_o == 3'd7, "R8 fault at limit", state_o, 7);
         pulse_arm(); cyc(3);
         chk(state_o == 3'd7, "R10 fault sticky", state_o, 7);
         pulse_clear();
         chk(state_o == 3'd0, "R10 clear leaves fault", state_o, 0);
      end

      // Timeout code zero never expires.
      timeout_code = 4'd0;
      pulse_arm();
      for (int i = 0; i < 20; i++) t1ms();
      chk(state_o == 3'd1, "R8 code zero disables timeout", state_o, 1);
      do_reset();

      // Watchdog on an unanswered request.
      holdoff_code = 4'd0; timeout_code = 4'd0; trig_sel = 2'd2;
      pulse_arm();
      trig_in[2] = 1'b1; cyc(3);
      t25();
      chk(state_o == 3'd3, "R9 measuring", state_o, 3);
      cyc(WDOG - 1);
      chk(state_o == 3'd3, "R9 no fault before budget", state_o, 3);
      cyc(1);
      chk(state_o == 3'd7, "R9 watchdog fault", state_o, 7);
      pulse_clear();
      chk(state_o == 3'd0, "R10 clear after watchdog", state_o, 0);
      trig_in = '0; cyc(4);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule